// File: doc/BRIEF.md
# Slow-Edge Synchronised Period Timer Controller

This block owns a 16-bit period counter and a 20-bit wrap counter that run on the fast system clock. Software starts or stops it with a run-control write. When the sync-enable input is low, a write takes effect on the next clock edge. When it is high, starts and stops wait for a rising edge of a slow 32 kHz clock. That clock arrives as an asynchronous level, passes through a two-flop synchroniser and then an edge detector. Stopping on such an edge stores the current 24-bit sleep-counter value.

A later synchronised start does not just resume counting. It starts an internal compensation engine that measures how many slow-clock periods passed while the timer was halted. It converts that figure into fast-clock cycles, adds the fixed length of the start sequence, and splits the result into a new counter value and a new wrap count. The counter therefore looks as if it had never stopped. The whole start sequence has a fixed length, so the overhead term is exact.

Top module: `sync_timer_ctrl`

## Requirements
- R1: With sync enabled, a run=0 write while running does not halt counting. The counter keeps incrementing up to and including the clock edge at which the synchronised slow-clock rise is acted on, and then stays frozen. A slow rise placed between two clock edges is acted on at the third clock edge after it.
- R2: At that stopping edge the sleep-counter input is stored, and the stored value is used by the next synchronised start.
- R3: With sync enabled, a run=1 write while stopped leaves `running_o` low and the counter frozen until a synchronised slow-clock rise arrives.
- R4: The synchronised start takes 75 system-clock cycles counted from the edge that acts on the slow rise. `running_o` and the new values appear at the 78th clock edge after the slow rise, and not at the 77th.
- R5: The loaded values follow from these quantities: D = (now − stored) mod 2^24, with D = 2^24 when the two are equal; C = round(D × 15625 / 16) + frozen counter + 75; the counter becomes C mod P; the wrap count becomes (C div P + frozen wrap count) mod 2^20.
- R6: A period input of 0 means a period of 65536, both for counting and in the R5 computation.
- R7: While running, the counter steps by one per clock. When it reaches P−1 it goes to 0 and the wrap count increments, and the wrap count rolls over at 2^20. With P = 1 the counter stays at 0 and the wrap count rises by one every cycle.
- R8: With sync disabled, a run=1 or run=0 write changes `running_o` at the clock edge that samples the write, and a stopped counter then holds its value.
- R9: A run write that reaches the block while a synchronised start or stop is pending replaces the pending request. A run=1 write during a pending stop keeps the timer running through the slow edge. A run=0 write during a pending start keeps it stopped with the counter unchanged.
- R10: After reset the block is stopped, with counter and wrap count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | Slow 32 kHz clock level, asynchronous |
| sync_en_i | input | 1 | 1: run writes wait for a slow-clock rise |
| run_wr_i | input | 1 | One-cycle strobe of a run-control write |
| run_val_i | input | 1 | Written run value (1 start, 0 stop) |
| sleep_val_i | input | 24 | Current sleep-counter value |
| period_i | input | 16 | Counter period P (0 means 65536) |
| timer_o | output | 16 | Current counter value |
| ovf_o | output | 20 | Current wrap count |
| running_o | output | 1 | 1 in run mode, 0 in idle mode |

## Verification
A controller stuck in a wait state shows up at once: `running_o` does not change at the expected edge, either the 3rd or the 78th after a slow rise. A wrong stored sleep value, a wrong rounding or a wrong divider result is hidden while the timer is halted. It appears only at the 78th edge after the start rise, as a counter or wrap value that differs from the R5 formula, so each start scenario compares both outputs exactly at that edge. A counter that keeps running, or fails to, after a stop shows up within a few cycles as a counter value that changes when it should hold, or holds when it should change.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ARM_START = 3'd1,
    ST_CALC      = 3'd2,
    ST_RUN       = 3'd3,
    ST_ARM_STOP  = 3'd4
  } stc_state_e;

endpackage

// File: rtl/stc_edge_sync.sv
module stc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  assign sync_d[0] = async_i;

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
      assign sync_d[g] = sync_q[g-1];
    end
  endgenerate

  assign last_d = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/stc_comp_calc.sv
module stc_comp_calc #(
  parameter int SW          = 24,
  parameter int TW          = 16,
  parameter int OW          = 20,
  parameter int OVERHEAD    = 75,
  parameter int RATIO_NUM   = 15625,
  parameter int RATIO_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [SW-1:0] now_sleep_i,
  input  logic [SW-1:0] held_sleep_i,
  input  logic [TW-1:0] cur_timer_i,
  input  logic [OW-1:0] cur_ovf_i,
  input  logic [TW-1:0] period_i,
  output logic          done_o,
  output logic [TW-1:0] new_timer_o,
  output logic [OW-1:0] new_ovf_o
);

  localparam int NUMW = $clog2(RATIO_NUM + 1);
  localparam int NDW  = SW + 1;
  localparam int PW   = NDW + NUMW;
  localparam int CW   = PW - RATIO_SHIFT + 1;
  localparam int RW   = TW + 1;
  localparam int ITW  = $clog2(CW);
  localparam logic [PW-1:0]  KMUL  = PW'(RATIO_NUM);
  localparam logic [PW-1:0]  HALF  = PW'((2 ** RATIO_SHIFT) / 2);
  localparam logic [ITW-1:0] LAST  = ITW'(CW - 1);

  // elapsed slow periods, scaled and rounded
  logic [SW-1:0]  diff;
  logic [NDW-1:0] nd;
  logic [PW-1:0]  prod;
  logic [PW-1:0]  rounded;
  logic [CW-1:0]  c_val;
  logic [RW-1:0]  peff;

  always_comb begin
    diff    = now_sleep_i - held_sleep_i;
    nd      = (diff == '0) ? {1'b1, {SW{1'b0}}} : {1'b0, diff};
    prod    = PW'(nd) * KMUL;
    rounded = prod + HALF;
    c_val   = CW'(rounded >> RATIO_SHIFT) + CW'(cur_timer_i) + CW'(OVERHEAD);
    peff    = (period_i == '0) ? {1'b1, {TW{1'b0}}} : {1'b0, period_i};
  end

  // serial restoring divider, one quotient bit per cycle
  logic [CW-1:0]  dvd_q, dvd_d;
  logic [RW-1:0]  rem_q, rem_d;
  logic [RW-1:0]  div_q, div_d;
  logic [OW-1:0]  oc_q, oc_d;
  logic [ITW-1:0] it_q, it_d;
  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic [RW:0]    rem_sh;
  logic [RW:0]    rem_nx;
  logic           fits;

  always_comb begin
    rem_sh = {rem_q, dvd_q[CW-1]};
    fits   = (rem_sh >= {1'b0, div_q});
    rem_nx = fits ? (rem_sh - {1'b0, div_q}) : rem_sh;

    dvd_d  = dvd_q;
    rem_d  = rem_q;
    div_d  = div_q;
    oc_d   = oc_q;
    it_d   = it_q;
    busy_d = busy_q;
    done_d = done_q;

    if (start_i) begin
      dvd_d  = c_val;
      rem_d  = '0;
      div_d  = peff;
      oc_d   = cur_ovf_i;
      it_d   = '0;
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (busy_q) begin
      dvd_d = {dvd_q[CW-2:0], fits};
      rem_d = RW'(rem_nx);
      it_d  = it_q + 1'b1;
      if (it_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      oc_q   <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dvd_q  <= dvd_d;
      rem_q  <= rem_d;
      div_q  <= div_d;
      oc_q   <= oc_d;
      it_q   <= it_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done_o      = done_q;
  assign new_timer_o = TW'(rem_q);
  assign new_ovf_o   = OW'(dvd_q) + oc_q;

endmodule

// File: rtl/stc_period_cnt.sv
module stc_period_cnt #(
  parameter int TW = 16,
  parameter int OW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_timer_i,
  input  logic [OW-1:0] load_ovf_i,
  input  logic [TW-1:0] period_i,
  output logic [TW-1:0] timer_o,
  output logic [OW-1:0] ovf_o
);

  localparam int RW = TW + 1;

  logic [TW-1:0] timer_q, timer_d;
  logic [OW-1:0] ovf_q, ovf_d;
  logic [RW-1:0] peff;
  logic          at_end;

  always_comb begin
    peff    = (period_i == '0) ? {1'b1, {TW{1'b0}}} : {1'b0, period_i};
    at_end  = ({1'b0, timer_q} >= (peff - 1'b1));
    timer_d = timer_q;
    ovf_d   = ovf_q;
    if (load_i) begin
      timer_d = load_timer_i;
      ovf_d   = load_ovf_i;
    end else if (count_en_i) begin
      if (at_end) begin
        timer_d = '0;
        ovf_d   = ovf_q + 1'b1;
      end else begin
        timer_d = timer_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      ovf_q   <= '0;
    end else begin
      timer_q <= timer_d;
      ovf_q   <= ovf_d;
    end
  end

  assign timer_o = timer_q;
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/sync_timer_ctrl.sv
module sync_timer_ctrl
  import stc_pkg::*;
#(
  parameter int SW          = 24,
  parameter int TW          = 16,
  parameter int OW          = 20,
  parameter int OVERHEAD    = 75,
  parameter int RATIO_NUM   = 15625,
  parameter int RATIO_SHIFT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_clk_i,
  input  logic          sync_en_i,
  input  logic          run_wr_i,
  input  logic          run_val_i,
  input  logic [SW-1:0] sleep_val_i,
  input  logic [TW-1:0] period_i,
  output logic [TW-1:0] timer_o,
  output logic [OW-1:0] ovf_o,
  output logic          running_o
);

  localparam int SEQW = $clog2(OVERHEAD);
  localparam logic [SEQW-1:0] SEQ_LAST = SEQW'(OVERHEAD - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic slow_edge;

  stc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_ni),
    .async_i (slow_clk_i),
    .rise_o  (slow_edge)
  );

  stc_state_e      state_q, state_d;
  logic [SEQW-1:0] seq_q, seq_d;
  logic [SW-1:0]   held_sleep_q, held_sleep_d;
  logic            cancel_start, cancel_stop;
  logic            calc_go, load_go, cap_go, seq_last;
  logic            calc_done;
  logic [TW-1:0]   calc_timer;
  logic [OW-1:0]   calc_ovf;

  always_comb begin
    seq_last     = (seq_q == SEQ_LAST);
    cancel_start = run_wr_i && (!sync_en_i || !run_val_i);
    cancel_stop  = run_wr_i && (!sync_en_i || run_val_i);
    calc_go      = (state_q == ST_ARM_START) && slow_edge && !cancel_start;
    load_go      = (state_q == ST_CALC) && seq_last && !cancel_start;
    cap_go       = (state_q == ST_ARM_STOP) && slow_edge && !cancel_stop;

    state_d = state_q;
    seq_d   = '0;
    unique case (state_q)
      ST_ARM_START: if (slow_edge) state_d = ST_CALC;
      ST_CALC: begin
        if (seq_last) state_d = ST_RUN;
        else          seq_d   = seq_q + 1'b1;
      end
      ST_ARM_STOP:  if (slow_edge) state_d = ST_IDLE;
      default: ;
    endcase

    // a run write replaces whatever is pending
    if (run_wr_i) begin
      if (!sync_en_i) begin
        state_d = run_val_i ? ST_RUN : ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE:              if (run_val_i)  state_d = ST_ARM_START;
          ST_ARM_START, ST_CALC: if (!run_val_i) state_d = ST_IDLE;
          ST_RUN:               if (!run_val_i) state_d = ST_ARM_STOP;
          ST_ARM_STOP:          if (run_val_i)  state_d = ST_RUN;
          default: ;
        endcase
      end
    end

    held_sleep_d = cap_go ? sleep_val_i : held_sleep_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      seq_q        <= '0;
      held_sleep_q <= '0;
    end else begin
      state_q      <= state_d;
      seq_q        <= seq_d;
      held_sleep_q <= held_sleep_d;
    end
  end

  assign running_o = (state_q == ST_RUN) || (state_q == ST_ARM_STOP);

  stc_comp_calc #(
    .SW          (SW),
    .TW          (TW),
    .OW          (OW),
    .OVERHEAD    (OVERHEAD),
    .RATIO_NUM   (RATIO_NUM),
    .RATIO_SHIFT (RATIO_SHIFT)
  ) u_calc (
    .clk          (clk),
    .rst_n        (rst_ni),
    .start_i      (calc_go),
    .now_sleep_i  (sleep_val_i),
    .held_sleep_i (held_sleep_q),
    .cur_timer_i  (timer_o),
    .cur_ovf_i    (ovf_o),
    .period_i     (period_i),
    .done_o       (calc_done),
    .new_timer_o  (calc_timer),
    .new_ovf_o    (calc_ovf)
  );

  stc_period_cnt #(.TW(TW), .OW(OW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_ni),
    .count_en_i   (running_o),
    .load_i       (load_go),
    .load_timer_i (calc_timer),
    .load_ovf_i   (calc_ovf),
    .period_i     (period_i),
    .timer_o      (timer_o),
    .ovf_o        (ovf_o)
  );

endmodule

// File: rtl/stc_checker.sv
module stc_checker
  import stc_pkg::*;
#(
  parameter int SW       = 24,
  parameter int TW       = 16,
  parameter int OVERHEAD = 75,
  parameter int SEQW     = 7
) (
  input logic            clk,
  input logic            rst_n,
  input stc_state_e      state,
  input logic            slow_edge,
  input logic            run_wr,
  input logic            run_val,
  input logic            sync_en,
  input logic            running,
  input logic [TW-1:0]   timer,
  input logic [TW-1:0]   period,
  input logic [SEQW-1:0] seq,
  input logic            load_go,
  input logic            calc_done,
  input logic [SW-1:0]   held_sleep,
  input logic [SW-1:0]   sleep_val
);

  logic [TW:0] peff;
  assign peff = (period == '0) ? {1'b1, {TW{1'b0}}} : {1'b0, period};

  assert_stop_waits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM_STOP && !slow_edge && !run_wr) |=> (running && state == ST_ARM_STOP));

  assert_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && $past(!running)) |-> $stable(timer));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM_STOP && slow_edge && !run_wr) |=> (held_sleep == $past(sleep_val) && !running));

  assert_start_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM_START && !slow_edge && !run_wr) |=> (!running && state == ST_ARM_START));

  assert_seq_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(running) && $past(state) == ST_CALC) |-> ($past(seq) == SEQW'(OVERHEAD - 1)));

  assert_calc_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> calc_done);

  assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && $stable(period) && $past(state) != ST_CALC) |-> ({1'b0, timer} < peff));

  assert_direct_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_wr && !sync_en) |=> (running == $past(run_val)));

endmodule

bind sync_timer_ctrl stc_checker #(
  .SW       (SW),
  .TW       (TW),
  .OVERHEAD (OVERHEAD),
  .SEQW     ($clog2(OVERHEAD))
) chk_i (
  .clk        (clk),
  .rst_n      (rst_ni),
  .state      (state_q),
  .slow_edge  (slow_edge),
  .run_wr     (run_wr_i),
  .run_val    (run_val_i),
  .sync_en    (sync_en_i),
  .running    (running_o),
  .timer      (timer_o),
  .period     (period_i),
  .seq        (seq_q),
  .load_go    (load_go),
  .calc_done  (calc_done),
  .held_sleep (held_sleep_q),
  .sleep_val  (sleep_val_i)
);

// File: tb/sync_timer_ctrl_tb_top.sv
`timescale 1ns/1ps
module sync_timer_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_clk;
  logic        sync_en;
  logic        run_wr;
  logic        run_val;
  logic [23:0] sleep_val;
  logic [15:0] period;
  logic [15:0] timer;
  logic [19:0] ovf;
  logic        running;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sync_timer_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_clk_i  (slow_clk),
    .sync_en_i   (sync_en),
    .run_wr_i    (run_wr),
    .run_val_i   (run_val),
    .sleep_val_i (sleep_val),
    .period_i    (period),
    .timer_o     (timer),
    .ovf_o       (ovf),
    .running_o   (running)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_run(bit v);
    run_wr  = 1'b1;
    run_val = v;
    tick(1);
    run_wr  = 1'b0;
  endtask

  task automatic slow_fall();
    slow_clk = 1'b0;
    tick(4);
  endtask

  function automatic longint peff_of(longint p);
    return (p == 0) ? 65536 : p;
  endfunction

  task automatic ref_calc(input longint nc, input longint ns, input longint tc,
                          input longint oc, input longint p,
                          output longint t, output longint o);
    longint nd, c, pe;
    nd = nc - ns;
    if (nd <= 0) nd = nd + (longint'(1) << 24);
    c  = ((nd * 15625) + 8) >>> 4;
    c  = c + tc + 75;
    pe = peff_of(p);
    t  = c % pe;
    o  = ((c / pe) + oc) % (longint'(1) << 20);
  endtask

  task automatic t_reset();
    chk("R10 running", running, 0);
    chk("R10 timer", timer, 0);
    chk("R10 ovf", ovf, 0);
  endtask

  task automatic t_direct();
    sync_en = 1'b0;
    period  = 16'd10;
    wr_run(1'b1);
    chk("R8 start next edge", running, 1);
    chk("R8 no count on write edge", timer, 0);
    tick(25);
    chk("R7 timer mod P", timer, 5);
    chk("R7 wrap count", ovf, 2);
    wr_run(1'b0);
    chk("R8 stop next edge", running, 0);
    chk("R8 last count", timer, 6);
    tick(5);
    chk("R8 held", timer, 6);
    chk("R8 held ovf", ovf, 2);
    period = 16'd1;
    wr_run(1'b1);
    tick(10);
    chk("R7 P=1 timer", timer, 0);
    chk("R7 P=1 ovf per cycle", ovf, 12);
    wr_run(1'b0);
  endtask

  task automatic t_sync(string tag, int p, int run_cycles, longint ns, longint nc);
    longint t0, tc, oc, et, eo;
    period    = 16'(p);
    sync_en   = 1'b0;
    wr_run(1'b1);
    tick(run_cycles);
    sleep_val = 24'(ns);
    sync_en   = 1'b1;
    wr_run(1'b0);
    tick(5);
    chk({tag, " R1 still running"}, running, 1);
    t0 = timer;
    slow_clk = 1'b1;
    tick(2);
    chk({tag, " R1 running before edge"}, running, 1);
    tick(1);
    chk({tag, " R1 stopped at edge"}, running, 0);
    chk({tag, " R1 counts to edge"}, timer, (t0 + 3) % peff_of(p));
    tc = timer;
    oc = ovf;
    slow_fall();
    chk({tag, " R1 frozen"}, timer, tc);
    sleep_val = 24'(nc);
    wr_run(1'b1);
    tick(20);
    chk({tag, " R3 idle before edge"}, running, 0);
    chk({tag, " R3 frozen"}, timer, tc);
    slow_clk = 1'b1;
    tick(77);
    chk({tag, " R4 not yet at 77"}, running, 0);
    tick(1);
    chk({tag, " R4 running at 78"}, running, 1);
    ref_calc(nc, ns, tc, oc, p, et, eo);
    chk({tag, " R5 timer"}, timer, et);
    chk({tag, " R5 ovf R2"}, ovf, eo);
    slow_fall();
    sync_en = 1'b0;
    wr_run(1'b0);
  endtask

  task automatic t_latest();
    longint ta;
    period  = 16'd100;
    sync_en = 1'b0;
    wr_run(1'b1);
    sync_en = 1'b1;
    wr_run(1'b0);
    tick(3);
    wr_run(1'b1);
    slow_clk = 1'b1;
    tick(5);
    chk("R9 stop cancelled", running, 1);
    ta = timer;
    tick(10);
    chk("R9 keeps counting", timer, (ta + 10) % 100);
    slow_fall();
    sync_en = 1'b0;
    wr_run(1'b0);
    ta = timer;
    sync_en = 1'b1;
    wr_run(1'b1);
    tick(3);
    wr_run(1'b0);
    slow_clk = 1'b1;
    tick(90);
    chk("R9 start cancelled", running, 0);
    chk("R9 counter unchanged", timer, ta);
    slow_fall();
  endtask

  initial begin
    rst_n = 1'b0; slow_clk = 1'b0; sync_en = 1'b0; run_wr = 1'b0;
    run_val = 1'b0; sleep_val = '0; period = 16'd10;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_direct();
    t_sync("S1", 1000, 40, 64'h000100, 64'h000105);
    t_sync("S2", 777, 123, 64'hFFFFF0, 64'h000010);
    t_sync("S3 R6", 0, 300, 64'h123456, 64'h123456);
    t_sync("S4 R7", 1, 17, 64'h000001, 64'h000000);
    t_latest();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule